// File: doc/BRIEF.md
# Interleaved Two-Bank DRAM Burst Sequencer

This block sits between a processor's local channel and a page-mode DRAM array built as two 32-bit banks. It serves instruction and data requests to one configured memory block. A request can be a single (simple) access or a burst. During a burst the block starts the second bank's row strobe one clock after the first. It then alternates column strobes between the banks, so that read data comes back at one word per clock.

Timing is chosen by three configuration inputs, which must be held stable while the block is busy:
- the row-strobe phase is 3 or 4 clocks;
- burst writes take 1 or 2 clocks per word;
- the byte numbering inside a word can be reversed.

Refresh timing is generated elsewhere. That logic raises `refresh_urgent` when a refresh has been waiting too long, and the block then cuts any running burst short at the next word.

Addresses are byte addresses. Their fields, from the bottom up, are:

| Bits | Field |
|---|---|
| 1:0 | byte within the word |
| 2 | bank select (0 = bank A, 1 = bank B) |
| next COL_W bits | column |
| next ROW_W bits | row |
| remaining upper bits | block base, compared with `cfg_base` |

Top module: `ilv_dram_seq`

## Requirements
- R1: A request is taken only when all of these hold: `bus_inv` is 0; the space code is right (`ispace` = 0 for instructions, `dspace` = 2'b00 for data); and the address's upper bits equal `cfg_base`. Any other request leaves every strobe and handshake inactive.
- R2: Cycle T0 is the clock after the edge that takes the request. The row strobe of the bank named by address bit 2 is low from T0 through T(L-1), where L = 3 when `cfg_ras3` = 1 and L = 4 otherwise. For a simple access the ready output of that request's kind is low in exactly one cycle, T(L).
- R3: After either bank's row strobe rises, it stays high for at least 2 clocks. Back-to-back simple accesses therefore start L+2 clocks apart. Back-to-back single-word bursts start L+3 clocks apart.
- R4: In a burst, the other bank's row strobe is low from T1 through the last word. Both row strobes hold through that word. Burst reads are ready on consecutive cycles from T(L).
- R5: Burst data writes are ready every clock when `cfg_wr1` = 1 and every second clock when `cfg_wr1` = 0. Word k is then ready at T(L+2k).
- R6: The burst request input of the request's kind is sampled in each ready cycle. A burst continues while it is 1 and `refresh_urgent` is 0. Otherwise the access ends with that word.
- R7: Word k of an access uses the word index {column, bank} plus k, wrapping inside the page. Its bank is the low bit of that index and its column is the upper bits. In each ready cycle, only that bank's column strobes are active and its address bus carries the column. In T0 the first bank's address bus carries the row.
- R8: For a data write, column strobe lane i covers bits 8i+7:8i. `dsize` 0 = byte, 1 = halfword, 2 or 3 = word. With `cfg_swap` = 0, byte address n selects lane n and a halfword selects lanes 1:0 or 3:2 by address bit 1. With `cfg_swap` = 1 the lanes are mirrored. Reads enable all four lanes. Word crossings are not detected.
- R9: When instruction and data requests arrive together, the data access runs first. The instruction access starts only after the data access and its precharge are complete.
- R10: All handshakes are active low and high whenever the block is not serving that kind. The burst acknowledge is low from T0 through the last word of a burst request. `pen_n` is low through a simple access.
- R11: Both write enables are low from T0 through the last word of a data write, and high otherwise. Instruction requests are always reads, whatever `rd_wr` shows.
- R12: Out of reset, all row and column strobes, write enables and handshakes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_base | input | 32-(3+COL_W+ROW_W) | Block base address (upper address bits) |
| cfg_ras3 | input | 1 | 1 = 3-clock row phase, 0 = 4-clock row phase |
| cfg_wr1 | input | 1 | 1 = one clock per burst write word, 0 = two clocks |
| cfg_swap | input | 1 | 1 = byte address 0 maps to bits 31:24 |
| bus_inv | input | 1 | Address and controls invalid when 1 |
| ireq | input | 1 | Instruction request |
| iburst | input | 1 | Instruction burst request |
| ispace | input | 1 | Instruction space code, must be 0 |
| dreq | input | 1 | Data request |
| dburst | input | 1 | Data burst request |
| dspace | input | 2 | Data space code, must be 00 |
| rd_wr | input | 1 | 1 = read, 0 = write (data only) |
| dsize | input | 2 | Data transfer size |
| addr | input | 32 | Byte address |
| refresh_urgent | input | 1 | Overdue refresh, ends a burst |
| ras_a_n | output | 1 | Bank A row strobe |
| ras_b_n | output | 1 | Bank B row strobe |
| cas_a_n | output | 4 | Bank A byte-lane column strobes |
| cas_b_n | output | 4 | Bank B byte-lane column strobes |
| we_a_n | output | 1 | Bank A write enable |
| we_b_n | output | 1 | Bank B write enable |
| ma_a | output | MA_W | Bank A row/column address |
| ma_b | output | MA_W | Bank B row/column address |
| irdy_n | output | 1 | Instruction ready |
| drdy_n | output | 1 | Data ready |
| iback_n | output | 1 | Instruction burst acknowledge |
| dback_n | output | 1 | Data burst acknowledge |
| pen_n | output | 1 | Pipeline enable |

## Verification
The embedded properties check the following on every clock:
- the two-clock minimum precharge after each row strobe rises;
- the two banks' row strobes never fall in the same cycle;
- at most one ready output is low at a time;
- every ready cycle has exactly one bank's column strobes active;
- an instruction ready never coincides with a write enable;
- the pipeline enable never coincides with a burst acknowledge.

The bench scenarios show what the properties cannot:
- the exact ready cycles for each phase length, write speed and burst length;
- the column sequence when it wraps at the page end;
- byte-lane selection in both byte orders;
- the spacing of back-to-back accesses;
- data-first ordering when both kinds of request arrive together;
- the rejection of requests that are invalid, in the wrong space or outside the block.

// File: rtl/ilv_dram_seq.sv
module ilv_dram_seq #(
  parameter int MA_W  = 11,
  parameter int COL_W = 10,
  parameter int ROW_W = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [31-(3+COL_W+ROW_W):0]   cfg_base,
  input  logic                          cfg_ras3,
  input  logic                          cfg_wr1,
  input  logic                          cfg_swap,
  input  logic                          bus_inv,
  input  logic                          ireq,
  input  logic                          iburst,
  input  logic                          ispace,
  input  logic                          dreq,
  input  logic                          dburst,
  input  logic [1:0]                    dspace,
  input  logic                          rd_wr,
  input  logic [1:0]                    dsize,
  input  logic [31:0]                   addr,
  input  logic                          refresh_urgent,
  output logic                          ras_a_n,
  output logic                          ras_b_n,
  output logic [3:0]                    cas_a_n,
  output logic [3:0]                    cas_b_n,
  output logic                          we_a_n,
  output logic                          we_b_n,
  output logic [MA_W-1:0]               ma_a,
  output logic [MA_W-1:0]               ma_b,
  output logic                          irdy_n,
  output logic                          drdy_n,
  output logic                          iback_n,
  output logic                          dback_n,
  output logic                          pen_n
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BLK_W = 3 + COL_W + ROW_W;
  localparam int WP_W  = COL_W + 1;

  logic             busy, first, sub, pre, is_data, is_wr, bacc, b0;
  logic [2:0]       t;
  logic [WP_W-1:0]  wptr;
  logic [ROW_W-1:0] row;
  logic [3:0]       lanes, lane_req;

  wire hit   = addr[31:BLK_W] == cfg_base;
  wire ok_i  = ireq && !bus_inv && !ispace && hit;
  wire ok_d  = dreq && !bus_inv && (dspace == 2'b00) && hit;
  wire start = !busy && !pre && (ok_i || ok_d);

  wire [2:0] lat  = cfg_ras3 ? 3'd3 : 3'd4;
  wire       slow = is_wr && !cfg_wr1;
  wire       rdy  = busy && (first ? (t == lat) : (!slow || sub));
  wire       bin  = is_data ? dburst : iburst;
  wire       more = bacc && bin && !refresh_urgent;

  wire cas_on  = busy && (!first || t >= lat - 3'd2);
  wire ras_1st = busy && (bacc || t < lat);
  wire ras_2nd = busy && bacc && (t != 3'd0);
  wire cas_a   = cas_on && !wptr[0];
  wire cas_b   = cas_on && wptr[0];

  always_comb begin
    case (dsize)
      2'd0:    lane_req = 4'b0001 << (cfg_swap ? ~addr[1:0] : addr[1:0]);
      2'd1:    lane_req = (addr[1] ^ cfg_swap) ? 4'b1100 : 4'b0011;
      default: lane_req = 4'b1111;
    endcase
    if (!(ok_d && !rd_wr)) lane_req = 4'b1111;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; first <= 1'b0; sub <= 1'b0; pre <= 1'b0;
      is_data <= 1'b0; is_wr <= 1'b0; bacc <= 1'b0; b0 <= 1'b0;
      t <= '0; wptr <= '0; row <= '0; lanes <= 4'hf;
    end else if (!busy) begin
      pre <= 1'b0;
      if (start) begin
        busy    <= 1'b1;
        first   <= 1'b1;
        sub     <= 1'b0;
        t       <= '0;
        is_data <= ok_d;
        is_wr   <= ok_d && !rd_wr;
        bacc    <= ok_d ? dburst : iburst;
        b0      <= addr[2];
        wptr    <= addr[2+COL_W:2];
        row     <= addr[BLK_W-1:3+COL_W];
        lanes   <= lane_req;
      end
    end else begin
      if (t != 3'd7) t <= t + 3'd1;
      if (rdy) begin
        if (more) begin
          first <= 1'b0;
          sub   <= 1'b0;
          wptr  <= wptr + WP_W'(1);
        end else begin
          busy <= 1'b0;
          pre  <= bacc;
        end
      end else if (!first) begin
        sub <= ~sub;
      end
    end
  end

  assign ras_a_n = !((ras_1st && !b0) || (ras_2nd && b0));
  assign ras_b_n = !((ras_1st && b0) || (ras_2nd && !b0));
  assign cas_a_n = ~(lanes & {4{cas_a}});
  assign cas_b_n = ~(lanes & {4{cas_b}});
  assign ma_a    = cas_a ? MA_W'(wptr[WP_W-1:1]) : MA_W'(row);
  assign ma_b    = cas_b ? MA_W'(wptr[WP_W-1:1]) : MA_W'(row);
  assign we_a_n  = !(busy && is_wr);
  assign we_b_n  = !(busy && is_wr);
  assign irdy_n  = !(rdy && !is_data);
  assign drdy_n  = !(rdy && is_data);
  assign iback_n = !(busy && bacc && !is_data);
  assign dback_n = !(busy && bacc && is_data);
  assign pen_n   = !(busy && !bacc);

  // R3
  prech_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_a_n) |=> ras_a_n);
  // R3
  prech_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_b_n) |=> ras_b_n);
  // R4
  stagger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(ras_a_n) && $fell(ras_b_n)));
  // R10
  one_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irdy_n || drdy_n);
  // R2
  rdy_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n || !drdy_n) |-> ((cas_a_n != 4'hf) != (cas_b_n != 4'hf)));
  // R11
  iread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irdy_n |-> (we_a_n && we_b_n));
  // R10
  pen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pen_n |-> (iback_n && dback_n));
endmodule

// File: tb/tb_ilv_dram_seq.sv
module tb_ilv_dram_seq;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [22:0] cfg_base = 23'h1234;
  logic cfg_ras3 = 1'b1, cfg_wr1 = 1'b1, cfg_swap = 1'b0;
  logic bus_inv = 1'b0, ireq = 1'b0, iburst = 1'b0, ispace = 1'b0;
  logic dreq = 1'b0, dburst = 1'b0, rd_wr = 1'b1, refresh_urgent = 1'b0;
  logic [1:0] dspace = 2'b00, dsize = 2'd2;
  logic [31:0] addr = '0;
  logic ras_a_n, ras_b_n, we_a_n, we_b_n, irdy_n, drdy_n, iback_n, dback_n, pen_n;
  logic [3:0] cas_a_n, cas_b_n;
  logic [10:0] ma_a, ma_b;
  int n_tests = 0, n_fail = 0;

  ilv_dram_seq #(.MA_W(11), .COL_W(3), .ROW_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ras3(cfg_ras3),
    .cfg_wr1(cfg_wr1), .cfg_swap(cfg_swap), .bus_inv(bus_inv), .ireq(ireq),
    .iburst(iburst), .ispace(ispace), .dreq(dreq), .dburst(dburst),
    .dspace(dspace), .rd_wr(rd_wr), .dsize(dsize), .addr(addr),
    .refresh_urgent(refresh_urgent), .ras_a_n(ras_a_n), .ras_b_n(ras_b_n),
    .cas_a_n(cas_a_n), .cas_b_n(cas_b_n), .we_a_n(we_a_n), .we_b_n(we_b_n),
    .ma_a(ma_a), .ma_b(ma_b), .irdy_n(irdy_n), .drdy_n(drdy_n),
    .iback_n(iback_n), .dback_n(dback_n), .pen_n(pen_n));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drv; @(posedge clk); #2; endtask
  task automatic smp; @(negedge clk); endtask

  function automatic int lanes_exp(int sz, int a, bit sw);
    int h, base;
    if (sz == 0) return 1 << (sw ? 3 - a : a);
    if (sz == 1) begin
      h = (a >> 1) & 1;
      base = sw ? (h ? 0 : 2) : (h ? 2 : 0);
      return 3 << base;
    end
    return 15;
  endfunction

  task automatic do_acc(input bit isd, input bit wr, input bit bst, input bit byref,
                        input int W, input int a, input int sz);
    int L, P, E, seen, b0, wst, row, msk, k, w, wb, rexp_i;
    bit wre, rexp, ract, oract, bk, obk, r0, r1;
    string rt;
    L = cfg_ras3 ? 3 : 4;
    wre = isd && wr;
    P = (wre && !cfg_wr1) ? 2 : 1;
    E = L + (W - 1) * P;
    seen = 0;
    b0 = (a >> 2) & 1;
    wst = (a >> 2) & 15;
    row = (a >> 6) & 7;
    msk = wre ? lanes_exp(sz, a & 3, cfg_swap) : 15;
    rt = !bst ? "R2" : (wre ? "R5" : "R4");
    drv;
    addr = {cfg_base, 9'(a)};
    rd_wr = !wr;
    dsize = 2'(sz);
    if (isd) begin dreq = 1'b1; dburst = bst; end
    else begin ireq = 1'b1; iburst = bst; end
    for (int j = 0; j <= E + 2; j++) begin
      drv;
      ireq = 1'b0; dreq = 1'b0;
      if (isd) dburst = bst && (byref || seen < W - 1);
      else iburst = bst && (byref || seen < W - 1);
      refresh_urgent = byref && (seen == W - 1);
      smp;
      rexp = (j >= L) && ((j - L) % P == 0) && ((j - L) / P < W);
      ract = isd ? !drdy_n : !irdy_n;
      oract = isd ? !irdy_n : !drdy_n;
      chk(ract == rexp, rt, int'(ract), int'(rexp));
      chk(!oract, "R10 other ready", int'(oract), 0);
      r0 = b0 ? !ras_b_n : !ras_a_n;
      r1 = b0 ? !ras_a_n : !ras_b_n;
      chk(r0 == (j < L || (bst && j <= E)), "R2 first RAS", int'(r0), int'(j < L || (bst && j <= E)));
      chk(r1 == (bst && j >= 1 && j <= E), "R4 second RAS", int'(r1), int'(bst && j >= 1 && j <= E));
      chk((!we_a_n == (wre && j <= E)) && (we_a_n == we_b_n), "R11 write enable",
          int'(!we_a_n), int'(wre && j <= E));
      bk = isd ? !dback_n : !iback_n;
      obk = isd ? !iback_n : !dback_n;
      chk(bk == (bst && j <= E), "R10 burst ack", int'(bk), int'(bst && j <= E));
      chk(!obk, "R10 other ack", int'(obk), 0);
      chk(!pen_n == (!bst && j <= E), "R10 pen", int'(!pen_n), int'(!bst && j <= E));
      if (j == 0) chk(int'(b0 ? ma_b : ma_a) == row, "R7 row", int'(b0 ? ma_b : ma_a), row);
      if (rexp) begin
        k = (j - L) / P;
        w = (wst + k) & 15;
        wb = w & 1;
        chk(int'(wb ? cas_b_n : cas_a_n) == (~msk & 15), wre ? "R8 lanes" : "R7 lanes",
            int'(wb ? cas_b_n : cas_a_n), ~msk & 15);
        chk(int'(wb ? cas_a_n : cas_b_n) == 15, "R7 idle bank CAS", int'(wb ? cas_a_n : cas_b_n), 15);
        chk(int'(wb ? ma_b : ma_a) == (w >> 1), "R7 column", int'(wb ? ma_b : ma_a), w >> 1);
        seen++;
      end
    end
    rexp_i = W;
    chk(seen == rexp_i, "R6 word count", seen, rexp_i);
    iburst = 1'b0; dburst = 1'b0; refresh_urgent = 1'b0;
  endtask

  task automatic reject_case(input int which);
    drv;
    addr = {cfg_base, 9'h150};
    case (which)
      0: begin bus_inv = 1'b1; dreq = 1'b1; end
      1: begin ispace = 1'b1; ireq = 1'b1; end
      2: begin dspace = 2'b01; dreq = 1'b1; end
      default: begin addr = {cfg_base + 23'd1, 9'h150}; dreq = 1'b1; end
    endcase
    for (int j = 0; j < 6; j++) begin
      smp;
      chk(ras_a_n && ras_b_n && irdy_n && drdy_n, "R1 rejected", int'({ras_a_n, ras_b_n, irdy_n, drdy_n}), 15);
      drv;
    end
    bus_inv = 1'b0; ispace = 1'b0; dspace = 2'b00; ireq = 1'b0; dreq = 1'b0;
    repeat (3) drv;
  endtask

  task automatic spacing(input bit bst);
    int L, last, falls, exp_gap;
    bit prev;
    L = cfg_ras3 ? 3 : 4;
    exp_gap = bst ? L + 3 : L + 2;
    last = -1; falls = 0; prev = 1'b1;
    drv;
    addr = {cfg_base, 9'h140};
    rd_wr = 1'b1; dreq = 1'b1; dburst = bst; refresh_urgent = bst;
    for (int j = 0; j < 40; j++) begin
      smp;
      if (prev && !ras_a_n) begin
        if (last >= 0) chk(j - last == exp_gap, "R3 access spacing", j - last, exp_gap);
        last = j;
        falls++;
      end
      prev = ras_a_n;
      drv;
    end
    dreq = 1'b0; dburst = 1'b0; refresh_urgent = 1'b0;
    chk(falls >= 4, "R3 access count", falls, 4);
    repeat (8) drv;
  endtask

  task automatic arbitrate;
    int L, dcyc, icyc, nd, ni;
    L = cfg_ras3 ? 3 : 4;
    dcyc = -1; icyc = -1; nd = 0; ni = 0;
    drv;
    addr = {cfg_base, 9'h140};
    rd_wr = 1'b1; dreq = 1'b1; ireq = 1'b1;
    for (int j = 0; j < 2 * L + 8; j++) begin
      drv;
      dreq = 1'b0;
      if (ni > 0) ireq = 1'b0;
      smp;
      if (!drdy_n) begin dcyc = j; nd++; end
      if (!irdy_n) begin icyc = j; ni++; end
    end
    ireq = 1'b0;
    chk(nd == 1 && dcyc == L, "R9 data first", dcyc, L);
    chk(ni == 1 && icyc == 2 * L + 2, "R9 instruction after", icyc, 2 * L + 2);
    repeat (4) drv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int a;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    smp;
    chk(ras_a_n && ras_b_n && we_a_n && we_b_n && cas_a_n == 4'hf && cas_b_n == 4'hf,
        "R12 strobes", int'({ras_a_n, ras_b_n, we_a_n, we_b_n}), 15);
    chk(irdy_n && drdy_n && iback_n && dback_n && pen_n, "R12 handshakes",
        int'({irdy_n, drdy_n, iback_n, dback_n, pen_n}), 31);

    for (int w = 0; w < 4; w++) reject_case(w);

    for (int c = 0; c < 8; c++) begin
      cfg_ras3 = c[0]; cfg_wr1 = c[1]; cfg_swap = c[2];
      for (int kind = 0; kind < 3; kind++) begin
        for (int ai = 0; ai < 4; ai++) begin
          a = (5 << 6) | (((ai >> 1) != 0 ? 7 : 0) << 3) | ((ai & 1) << 2);
          do_acc(kind != 0, kind != 1, 1'b0, 1'b0, 1, a, 2);
          for (int w = 1; w <= 4; w++) do_acc(kind != 0, kind != 1, 1'b1, 1'b0, w, a, 2);
          for (int w = 1; w <= 3; w++) do_acc(kind != 0, kind != 1, 1'b1, 1'b1, w, a, 2);
        end
      end
    end

    cfg_ras3 = 1'b1; cfg_wr1 = 1'b1;
    for (int sw = 0; sw < 2; sw++) begin
      cfg_swap = sw[0];
      for (int sz = 0; sz < 3; sz++)
        for (int b = 0; b < 4; b++)
          do_acc(1'b1, 1'b1, 1'b0, 1'b0, 1, (5 << 6) | (2 << 3) | b, sz);
    end
    cfg_swap = 1'b0;

    for (int r = 0; r < 2; r++) begin
      cfg_ras3 = r[0];
      spacing(1'b0);
      spacing(1'b1);
      arbitrate();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule